// File: doc/BRIEF.md
# Cart Running-Total Price Unit

This block keeps the money total for a cart of scanned items. A 3-bit command and a 16-bit data word arrive together. Some commands load a price into a 32-entry price table. Others look up an item's price by its 5-bit code and then add it to, or take it from, a running subtotal. At checkout the block deducts a coupon, applies a fixed-point tax rate, and presents the taxed total and the tax amount. It also shows the price of the most recently handled item. All amounts are whole cents.

A controlling agent puts a command on `op_i` for one cycle while `busy_o` is low, and then waits for `busy_o` to fall. The state machine has six states. `IDLE` accepts commands. `FETCH` reads the price table. `ACCUM` adds or subtracts the fetched price. `COUPON` subtracts a coupon amount. `TAX` forms the product of the subtotal and the rate. `FINISH` publishes the total and pulses `done_o`.

The transitions are as follows:
- IDLE goes to FETCH on insert or remove, to COUPON on coupon, and to TAX on checkout.
- IDLE stays in IDLE on write and on every other code.
- FETCH goes to ACCUM.
- ACCUM and COUPON go back to IDLE.
- TAX goes to FINISH, and FINISH goes to IDLE.

Top module: `cart_total_top`

## Requirements
- R1: After reset, every output is zero, `busy_o` is low and every price table entry reads as zero.
- R2: Command 011 (write) stores `din_i[9:0]` as the price of item `din_i[14:10]` in the same cycle. It does not change the subtotal, final total, tax or last price, and `busy_o` stays low.
- R3: Command 001 (insert) takes the item code from `din_i[4:0]`. It adds that item's price to the subtotal and copies the price to `last_price_o`. `busy_o` is high for exactly 2 cycles, and the results show in the cycle in which `busy_o` falls.
- R4: Command 010 (remove) takes the item code from `din_i[4:0]`. It subtracts that item's price from the subtotal and copies the price to `last_price_o`. If the price exceeds the subtotal, the subtotal becomes zero. `busy_o` is high for 2 cycles.
- R5: An insert that would take the subtotal above 2^21-1 leaves it at 2^21-1.
- R6: Command 100 (coupon) subtracts the whole 16-bit `din_i` from the subtotal, with a floor at zero. `busy_o` is high for 1 cycle.
- R7: Command 101 (checkout) treats `din_i` as a tax rate with 12 fractional bits. The final total is floor(subtotal × rate / 4096), capped at 2^21-1. The tax output is the final total minus the subtotal, or zero if that difference is negative. The subtotal is then cleared and `last_price_o` is unchanged. `busy_o` is high for 2 cycles.
- R8: `done_o` is high for exactly one cycle after each checkout: the cycle in which the new final total first shows. It is low at all other times.
- R9: Any command presented while `busy_o` is high is ignored.
- R10: Command 000 and the unused codes 110 and 111 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Command code |
| din_i | input | 16 | Command data: item code, price entry, coupon or tax rate |
| busy_o | output | 1 | High while a command is in progress |
| done_o | output | 1 | One-cycle checkout completion pulse |
| subtotal_o | output | 21 | Running subtotal in cents |
| final_o | output | 21 | Taxed total from the last checkout |
| tax_o | output | 21 | Tax amount from the last checkout |
| last_price_o | output | 10 | Price of the last inserted or removed item |

## Verification
The hardest state to reach from the ports is a subtotal pinned at its upper limit. With a 10-bit price ceiling, reaching it takes more than two thousand inserts. The bench loads the largest price into one entry and runs a long directed insert burst. It then shows that removals and coupons bring the total down from the cap correctly. Commands injected while `busy_o` is high are also produced on purpose. The bench drives a spurious insert in the first busy cycle of random operations and checks that the modelled totals do not move.

// File: rtl/cart_pkg.sv
package cart_pkg;
    localparam int CODE_W  = 5;
    localparam int PRICE_W = 10;
    localparam int TOTAL_W = 21;
    localparam int DIN_W   = 16;
    localparam int FRAC_W  = 12;

    typedef enum logic [2:0] {
        OP_NONE     = 3'b000,
        OP_INSERT   = 3'b001,
        OP_REMOVE   = 3'b010,
        OP_WRITE    = 3'b011,
        OP_COUPON   = 3'b100,
        OP_CHECKOUT = 3'b101
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_ACCUM,
        S_COUPON,
        S_TAX,
        S_FINISH
    } state_e;
endpackage

// File: rtl/cart_price_table.sv
module cart_price_table #(
    parameter int AW = 5,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                entry_q[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))
                entry_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= entry_q[rd_addr];
    end
endmodule

// File: rtl/cart_accum.sv
module cart_accum #(
    parameter int W   = 21,
    parameter int OPW = 16
) (
    input  logic [W-1:0]   acc_i,
    input  logic [OPW-1:0] opd_i,
    input  logic           sub_en_i,
    output logic [W-1:0]   acc_o
);
    logic [W:0] opd_ext;
    logic [W:0] sum;

    assign opd_ext = {{(W+1-OPW){1'b0}}, opd_i};

    always_comb begin
        sum = '0;
        if (sub_en_i) begin
            if (opd_ext > {1'b0, acc_i})
                acc_o = '0;
            else begin
                sum   = {1'b0, acc_i} - opd_ext;
                acc_o = sum[W-1:0];
            end
        end else begin
            sum   = {1'b0, acc_i} + opd_ext;
            acc_o = sum[W] ? '1 : sum[W-1:0];
        end
    end
endmodule

// File: rtl/cart_tax.sv
module cart_tax #(
    parameter int W    = 21,
    parameter int RW   = 16,
    parameter int FRAC = 12
) (
    input  logic [W+RW-1:0] prod_i,
    input  logic [W-1:0]    base_i,
    output logic [W-1:0]    total_o,
    output logic [W-1:0]    tax_o
);
    localparam int PW = W + RW;

    logic [PW-1:0] scaled;
    logic          over;

    assign scaled  = prod_i >> FRAC;
    assign over    = |scaled[PW-1:W];
    assign total_o = over ? '1 : scaled[W-1:0];
    assign tax_o   = (total_o > base_i) ? (total_o - base_i) : '0;
endmodule

// File: rtl/cart_total_top.sv
module cart_total_top
    import cart_pkg::*;
#(
    parameter int CODE_BITS  = CODE_W,
    parameter int PRICE_BITS = PRICE_W,
    parameter int TOTAL_BITS = TOTAL_W,
    parameter int DATA_BITS  = DIN_W,
    parameter int FRAC_BITS  = FRAC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            op_i,
    input  logic [DATA_BITS-1:0]  din_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [TOTAL_BITS-1:0] subtotal_o,
    output logic [TOTAL_BITS-1:0] final_o,
    output logic [TOTAL_BITS-1:0] tax_o,
    output logic [PRICE_BITS-1:0] last_price_o
);
    localparam int PROD_BITS = TOTAL_BITS + DATA_BITS;

    state_e state_q, state_d;
    op_e    cmd;

    logic [CODE_BITS-1:0]  code_q;
    logic                  remove_q;
    logic [DATA_BITS-1:0]  coupon_q;
    logic [DATA_BITS-1:0]  rate_q;
    logic [PROD_BITS-1:0]  prod_q;
    logic [TOTAL_BITS-1:0] sub_q, final_q, tax_q;
    logic [PRICE_BITS-1:0] last_q;
    logic                  done_q;

    logic                  tbl_wr;
    logic [PRICE_BITS-1:0] tbl_rd_data;
    logic [DATA_BITS-1:0]  acc_opd;
    logic                  acc_sub;
    logic [TOTAL_BITS-1:0] acc_res;
    logic [TOTAL_BITS-1:0] tax_total, tax_amt;

    assign cmd    = op_e'(op_i);
    assign tbl_wr = (state_q == S_IDLE) && (cmd == OP_WRITE);

    cart_price_table #(.AW(CODE_BITS), .DW(PRICE_BITS)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr),
        .wr_addr (din_i[PRICE_BITS +: CODE_BITS]),
        .wr_data (din_i[PRICE_BITS-1:0]),
        .rd_en   (state_q == S_FETCH),
        .rd_addr (code_q),
        .rd_data (tbl_rd_data)
    );

    assign acc_opd = (state_q == S_COUPON) ? coupon_q
                                           : {{(DATA_BITS-PRICE_BITS){1'b0}}, tbl_rd_data};
    assign acc_sub = (state_q == S_COUPON) || remove_q;

    cart_accum #(.W(TOTAL_BITS), .OPW(DATA_BITS)) u_accum (
        .acc_i    (sub_q),
        .opd_i    (acc_opd),
        .sub_en_i (acc_sub),
        .acc_o    (acc_res)
    );

    cart_tax #(.W(TOTAL_BITS), .RW(DATA_BITS), .FRAC(FRAC_BITS)) u_tax (
        .prod_i  (prod_q),
        .base_i  (sub_q),
        .total_o (tax_total),
        .tax_o   (tax_amt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd == OP_INSERT || cmd == OP_REMOVE)
                    state_d = S_FETCH;
                else if (cmd == OP_COUPON)
                    state_d = S_COUPON;
                else if (cmd == OP_CHECKOUT)
                    state_d = S_TAX;
            end
            S_FETCH:  state_d = S_ACCUM;
            S_ACCUM:  state_d = S_IDLE;
            S_COUPON: state_d = S_IDLE;
            S_TAX:    state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= '0;
            remove_q <= 1'b0;
            coupon_q <= '0;
            rate_q   <= '0;
            prod_q   <= '0;
            sub_q    <= '0;
            final_q  <= '0;
            tax_q    <= '0;
            last_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    code_q   <= din_i[CODE_BITS-1:0];
                    remove_q <= (cmd == OP_REMOVE);
                    coupon_q <= din_i;
                    rate_q   <= din_i;
                end
                S_FETCH: ;
                S_ACCUM: begin
                    sub_q  <= acc_res;
                    last_q <= tbl_rd_data;
                end
                S_COUPON: sub_q <= acc_res;
                S_TAX: prod_q <= PROD_BITS'(sub_q) * PROD_BITS'(rate_q);
                S_FINISH: begin
                    final_q <= tax_total;
                    tax_q   <= tax_amt;
                    sub_q   <= '0;
                    done_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy_o       = (state_q != S_IDLE);
    assign done_o       = done_q;
    assign subtotal_o   = sub_q;
    assign final_o      = final_q;
    assign tax_o        = tax_q;
    assign last_price_o = last_q;

    assert_insert_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACCUM && !remove_q) |=> subtotal_o >= $past(subtotal_o));
    assert_remove_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACCUM && remove_q) |=> subtotal_o <= $past(subtotal_o));
    assert_coupon_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COUPON) |=> subtotal_o <= $past(subtotal_o));
    assert_write_no_total_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr |=> ($stable(subtotal_o) && $stable(final_o) && !busy_o));
    assert_checkout_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINISH) |=> (subtotal_o == '0 && done_o));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACCUM || state_q == S_COUPON || state_q == S_FINISH) |=> !busy_o);
    assert_unused_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && op_i inside {3'b000, 3'b110, 3'b111}) |=>
            (!busy_o && $stable(subtotal_o) && $stable(last_price_o)));
endmodule

// File: tb/test_cart_total_top.sv
module test_cart_total_top;
    localparam int MAXT = (1 << 21) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'b000;
    logic [15:0] din_i = '0;
    logic        busy_o, done_o;
    logic [20:0] subtotal_o, final_o, tax_o;
    logic [9:0]  last_price_o;

    int total = 0;
    int bad = 0;
    int m_price [32];
    int m_sub = 0, m_final = 0, m_tax = 0, m_last = 0;
    int busy_cnt;
    bit done_seen;

    always #4 clk = ~clk;

    cart_total_top i_cart_total_top (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .din_i(din_i),
        .busy_o(busy_o), .done_o(done_o), .subtotal_o(subtotal_o),
        .final_o(final_o), .tax_o(tax_o), .last_price_o(last_price_o)
    );

    task automatic check(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat_add(int a, int b);
        return (a + b > MAXT) ? MAXT : a + b;
    endfunction

    function automatic int floor_sub(int a, int b);
        return (b > a) ? 0 : a - b;
    endfunction

    function automatic int taxed(int s, int rate);
        longint p = (longint'(s) * longint'(rate)) >>> 12;
        return (p > MAXT) ? MAXT : int'(p);
    endfunction

    // drive one command; poke is driven during the first busy cycle
    task automatic run_op(logic [2:0] op, logic [15:0] d, logic [2:0] poke);
        @(negedge clk);
        op_i = op; din_i = d;
        @(negedge clk);
        op_i = poke; din_i = 16'h0001;
        busy_cnt = 0; done_seen = 1'b0;
        while (busy_o && busy_cnt < 10) begin
            busy_cnt++;
            @(negedge clk);
            op_i = 3'b000;
        end
        op_i = 3'b000;
        done_seen = done_o;
    endtask

    task automatic do_write(int code, int price);
        run_op(3'b011, 16'((code << 10) | price), 3'b000);
        m_price[code] = price;
        check("R2", "busy cycles", busy_cnt, 0);
        check("R2", "subtotal", subtotal_o, m_sub);
        check("R2", "last", last_price_o, m_last);
    endtask

    task automatic do_item(bit rem, int code, logic [2:0] poke);
        run_op(rem ? 3'b010 : 3'b001, 16'(code), poke);
        m_sub  = rem ? floor_sub(m_sub, m_price[code]) : sat_add(m_sub, m_price[code]);
        m_last = m_price[code];
        check(rem ? "R4" : "R3", "busy cycles", busy_cnt, 2);
        check(rem ? "R4" : "R3", "subtotal", subtotal_o, m_sub);
        check(rem ? "R4" : "R3", "last", last_price_o, m_last);
        check("R8", "done off", done_seen, 0);
    endtask

    task automatic do_coupon(int amt, logic [2:0] poke);
        run_op(3'b100, 16'(amt), poke);
        m_sub = floor_sub(m_sub, amt);
        check("R6", "busy cycles", busy_cnt, 1);
        check("R6", "subtotal", subtotal_o, m_sub);
    endtask

    task automatic do_checkout(int rate, logic [2:0] poke);
        run_op(3'b101, 16'(rate), poke);
        m_final = taxed(m_sub, rate);
        m_tax   = floor_sub(m_final, m_sub);
        m_sub   = 0;
        check("R7", "busy cycles", busy_cnt, 2);
        check("R7", "final", final_o, m_final);
        check("R7", "tax", tax_o, m_tax);
        check("R7", "subtotal cleared", subtotal_o, 0);
        check("R7", "last kept", last_price_o, m_last);
        check("R8", "done pulse", done_seen, 1);
        @(negedge clk);
        check("R8", "done drops", done_o, 0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) m_price[i] = 0;
        repeat (3) @(negedge clk);
        check("R1", "busy", busy_o, 0);
        check("R1", "subtotal", subtotal_o, 0);
        check("R1", "final", final_o, 0);
        check("R1", "done", done_o, 0);
        rst_n = 1'b1;
        // R1: table reads zero after reset
        do_item(1'b0, 7, 3'b000);
        check("R1", "table entry", last_price_o, 0);

        // directed basic flow
        do_write(3, 250);
        do_write(31, 1023);
        do_item(1'b0, 3, 3'b000);
        do_item(1'b0, 31, 3'b000);
        do_item(1'b1, 3, 3'b000);
        do_item(1'b1, 31, 3'b000);
        do_item(1'b1, 31, 3'b000);          // R4 floor at zero
        do_item(1'b0, 3, 3'b000);
        do_coupon(1000, 3'b000);            // R6 floor at zero
        do_item(1'b0, 31, 3'b000);
        do_checkout(4096 + 328, 3'b000);   // R7 8 percent
        do_item(1'b0, 3, 3'b000);
        do_checkout(2048, 3'b000);          // R7 rate below one: tax zero

        // R10: null and unused codes
        do_item(1'b0, 31, 3'b000);
        foreach (op_i[k]) begin end
        run_op(3'b000, 16'h7fff, 3'b000);
        check("R10", "op000 subtotal", subtotal_o, m_sub);
        run_op(3'b110, 16'h0003, 3'b000);
        check("R10", "op110 subtotal", subtotal_o, m_sub);
        check("R10", "op110 busy", busy_cnt, 0);
        run_op(3'b111, 16'h0003, 3'b000);
        check("R10", "op111 last", last_price_o, m_last);

        // R5: drive to the cap
        for (int i = 0; i < 2060; i++) begin
            run_op(3'b001, 16'd31, 3'b000);
            m_sub = sat_add(m_sub, 1023);
        end
        check("R5", "saturated", subtotal_o, MAXT);
        do_item(1'b0, 31, 3'b000);
        do_item(1'b1, 3, 3'b000);
        do_coupon(65535, 3'b000);
        do_checkout(16'hffff, 3'b000);     // R7 cap on total

        // random mix, with R9 pokes during busy
        for (int i = 0; i < 600; i++) begin
            int sel = $urandom_range(0, 9);
            logic [2:0] pk = ($urandom_range(0, 1) == 1) ? 3'b001 : 3'b000;
            if (sel < 2)
                do_write($urandom_range(0, 31), $urandom_range(0, 1023));
            else if (sel < 6)
                do_item(1'b0, $urandom_range(0, 31), pk);
            else if (sel < 8)
                do_item(1'b1, $urandom_range(0, 31), pk);
            else if (sel < 9)
                do_coupon($urandom_range(0, 3000), pk);
            else
                do_checkout(($urandom_range(0, 3) == 0) ? $urandom_range(0, 65535)
                                                        : $urandom_range(4096, 5000), pk);
        end
        check("R9", "final subtotal after pokes", subtotal_o, m_sub);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule